// File: doc/BRIEF.md
# Link Training Test Sequencer

This block drives a receiver compliance run against one lane of a four-lane display sink. It talks to the sink through an abstract register port that stands in for the sideband channel. It moves a pattern source through five stimulus steps using an index handshake. In each step it programs the sink, waits, polls status or reads the lane's error counter, and decides whether to continue. When the run ends it raises `done_o` for one cycle and returns pass, or a failure code that names the step that failed.

The steps always run in this order. First comes frequency (clock recovery) lock. Symbol lock follows. Next is an error-counter sanity check on a clean pattern, then a check with a known number of injected single-bit errors. Last is a timed bit-error-rate run. The lock steps retry up to a set limit. The register port may defer any transaction. A deferred transaction is reissued, but only up to a limit on consecutive defers. The status bit positions and the counter addresses depend on the lane under test. The lock settle time and the observation time are counted in clock cycles set by parameters.

Top module: `lt_test_seq`

## Requirements
- R1: Pattern indices are requested in the order 0 (frequency lock), 1 (symbol lock), 2 (clean), 3 (injected errors), 4 (stressed run). `pat_req_o` and `pat_idx_o` hold until `pat_ack_i`. A failing run requests no index past the step that failed.
- R2: Each attempt of a lock step starts with a write to address 0x102. Bit 5 is set to disable scrambling, and bits 1:0 hold 1 for frequency lock or 2 for symbol lock (data 0x21 or 0x22). No other write is issued.
- R3: A status poll, or the injected-error counter read, starts more than `LOCK_WAIT` cycles after the training write (or the pattern acknowledge) that started it.
- R4: Frequency lock is taken from the clock-recovery bit of the lane. That bit is 0x202 bit 0 for lane 0, 0x202 bit 4 for lane 1, 0x203 bit 0 for lane 2 and 0x203 bit 4 for lane 3. Bits of other lanes are ignored.
- R5: Symbol lock needs both the equalisation-done bit and the symbol-locked bit of the lane. These are bits 1 and 2 for even lanes and bits 5 and 6 for odd lanes, in 0x202 for lanes 0 and 1 and in 0x203 for lanes 2 and 3.
- R6: A lock step makes one attempt plus at most `MAX_RETRY` (5) retries. If the last poll fails, the run ends with code 1 (frequency) or 2 (symbol).
- R7: A deferred transaction is reissued unchanged. The counter of consecutive defers is cleared by an acknowledge. The defer that would be number `MAX_DEFER`+1 (the 9th) ends the run with code 6.
- R8: The lane's 16-bit error counter is read low byte first at 0x210+2*lane, then high byte at the next address. In the clean step a nonzero count ends the run with code 3.
- R9: After `inj_cnt_i` (n) injected errors, the count must be n or n+1. Any other count ends the run with code 4.
- R10: The stressed step reads the counter once to clear it, waits more than `OBS_CYC` cycles, then reads it again. It passes when the count is below `err_limit_i` and otherwise ends with code 5.
- R11: After reset, and after any run, `done_o` pulses for exactly one cycle. While it is high, `pass_o` is 1 exactly when `fail_code_o` is 0. Reset returns every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle |
| lane_i | input | 2 | Lane under test, sampled at start |
| inj_cnt_i | input | DW | Number of injected single-bit errors, sampled at start |
| err_limit_i | input | 2*DW | Error limit for the stressed run, sampled at start |
| pat_req_o | output | 1 | Pattern step request |
| pat_idx_o | output | 3 | Requested pattern index |
| pat_ack_i | input | 1 | Pattern source has switched |
| req_o | output | 1 | Register transaction pending |
| we_o | output | 1 | 1 = write, 0 = read |
| addr_o | output | AW | Register address |
| wdata_o | output | DW | Write data |
| ack_i | input | 1 | Transaction completed this cycle |
| defer_i | input | 1 | Transaction deferred this cycle |
| rdata_i | input | DW | Read data, valid with ack_i |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run passed, held until next start |
| fail_code_o | output | 3 | 0 pass, 1 freq lock, 2 symbol lock, 3 clean count, 4 injected count, 5 error limit, 6 defer overrun |

## Verification
An acknowledge on the register port reaches the FSM one cycle later. It then takes one more cycle to dispatch and another to issue, so a new request appears three cycles after the acknowledge, or `LOCK_WAIT`+4 cycles later when a wait comes between. The bench never counts on a fixed latency. The sink model answers each request on the falling edge after it appears. Timing checks measure the gap between an acknowledge and the next request against a bound taken from R3 or R10. End-of-run results are sampled on the falling edge where `done_o` is first seen high, and the next falling edge confirms the pulse has ended.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int REG_TPS  = 'h102;
  localparam int REG_STAT = 'h202;
  localparam int REG_CNT  = 'h210;

  typedef enum logic [2:0] {
    S_IDLE, S_PAT, S_ISSUE, S_XWAIT, S_WAIT, S_END
  } st_e;

  // value equals the pattern index
  typedef enum logic [2:0] {
    PH_FL = 3'd0, PH_SL = 3'd1, PH_CLEAN = 3'd2, PH_INJ = 3'd3, PH_BER = 3'd4
  } ph_e;

  typedef enum logic [1:0] {OP_TPS, OP_POLL, OP_LO, OP_HI} op_e;

  localparam logic [2:0] FC_NONE  = 3'd0;
  localparam logic [2:0] FC_FL    = 3'd1;
  localparam logic [2:0] FC_SL    = 3'd2;
  localparam logic [2:0] FC_CLEAN = 3'd3;
  localparam logic [2:0] FC_INJ   = 3'd4;
  localparam logic [2:0] FC_BER   = 3'd5;
  localparam logic [2:0] FC_DEFER = 3'd6;
endpackage

// File: rtl/lt_lane_map.sv
module lt_lane_map #(
  parameter int AW = 12
) (
  input  logic [1:0]    lane_i,
  output logic [AW-1:0] stat_addr_o,
  output logic [AW-1:0] cnt_addr_o,
  output logic [2:0]    cr_bit_o,
  output logic [2:0]    eq_bit_o,
  output logic [2:0]    sl_bit_o
);
  import lt_pkg::*;

  logic [2:0] nib;

  always_comb begin
    // two lanes per status byte, odd lane in the upper nibble
    stat_addr_o = AW'(REG_STAT) + AW'(lane_i[1]);
    cnt_addr_o  = AW'(REG_CNT) + AW'({lane_i, 1'b0});
    nib         = lane_i[0] ? 3'd4 : 3'd0;
    cr_bit_o    = nib;
    eq_bit_o    = nib + 3'd1;
    sl_bit_o    = nib + 3'd2;
  end
endmodule

// File: rtl/lt_tmr.sv
module lt_tmr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (load_i)      cnt <= val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/lt_xact.sv
module lt_xact #(
  parameter int AW        = 12,
  parameter int DW        = 8,
  parameter int MAX_DEFER = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  input  logic          defer_i,
  input  logic [DW-1:0] rdata_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [DW-1:0] rdata_o
);
  localparam int DCW = $clog2(MAX_DEFER + 1);

  logic [DCW-1:0] dcnt;
  logic           dlim;

  assign dlim = (dcnt == DCW'(MAX_DEFER));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      dcnt    <= '0;
      done_o  <= 1'b0;
      fail_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      if (go_i && !req_o) begin
        req_o   <= 1'b1;
        we_o    <= we_i;
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end else if (req_o) begin
        if (ack_i) begin
          req_o   <= 1'b0;
          done_o  <= 1'b1;
          rdata_o <= rdata_i;
          dcnt    <= '0;
        end else if (defer_i) begin
          if (dlim) begin
            req_o  <= 1'b0;
            fail_o <= 1'b1;
            dcnt   <= '0;
          end else begin
            dcnt <= dcnt + 1'b1;   // reissue unchanged
          end
        end
      end
    end
  end

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && !(defer_i && dlim)) |=>
      (req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)));

  p_defer_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcnt <= DCW'(MAX_DEFER));

  p_done_fail_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
endmodule

// File: rtl/lt_test_seq.sv
module lt_test_seq #(
  parameter int AW        = 12,
  parameter int DW        = 8,
  parameter int LOCK_WAIT = 10001,
  parameter int OBS_CYC   = 1000000,
  parameter int MAX_RETRY = 5,
  parameter int MAX_DEFER = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      lane_i,
  input  logic [DW-1:0]   inj_cnt_i,
  input  logic [2*DW-1:0] err_limit_i,
  output logic            pat_req_o,
  output logic [2:0]      pat_idx_o,
  input  logic            pat_ack_i,
  output logic            req_o,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o,
  input  logic            ack_i,
  input  logic            defer_i,
  input  logic [DW-1:0]   rdata_i,
  output logic            done_o,
  output logic            pass_o,
  output logic [2:0]      fail_code_o
);
  import lt_pkg::*;

  localparam int CW   = 2 * DW;
  localparam int TMAX = (OBS_CYC > LOCK_WAIT) ? OBS_CYC : LOCK_WAIT;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(MAX_RETRY + 1);

  st_e           st;
  ph_e           phase;
  op_e           op;
  logic [1:0]    lane_q;
  logic [DW-1:0] inj_q;
  logic [CW-1:0] lim_q;
  logic [RW-1:0] tries;
  logic          clr_done;
  logic [DW-1:0] cnt_lo;
  logic [CW-1:0] cnt_full;

  logic [AW-1:0] stat_addr, cnt_addr;
  logic [2:0]    cr_bit, eq_bit, sl_bit;

  logic          x_go, x_we, x_done, x_fail;
  logic [AW-1:0] x_addr;
  logic [DW-1:0] x_wdata, x_rdata;

  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          lock_ok, inj_ok;

  lt_lane_map #(.AW(AW)) u_map (
    .lane_i      (lane_q),
    .stat_addr_o (stat_addr),
    .cnt_addr_o  (cnt_addr),
    .cr_bit_o    (cr_bit),
    .eq_bit_o    (eq_bit),
    .sl_bit_o    (sl_bit)
  );

  lt_xact #(.AW(AW), .DW(DW), .MAX_DEFER(MAX_DEFER)) u_xact (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (x_go),
    .we_i    (x_we),
    .addr_i  (x_addr),
    .wdata_i (x_wdata),
    .req_o   (req_o),
    .we_o    (we_o),
    .addr_o  (addr_o),
    .wdata_o (wdata_o),
    .ack_i   (ack_i),
    .defer_i (defer_i),
    .rdata_i (rdata_i),
    .done_o  (x_done),
    .fail_o  (x_fail),
    .rdata_o (x_rdata)
  );

  lt_tmr #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .zero_o (t_zero)
  );

  // transaction mux
  always_comb begin
    x_go    = (st == S_ISSUE);
    x_we    = 1'b0;
    x_addr  = '0;
    x_wdata = '0;
    unique case (op)
      OP_TPS: begin
        x_we    = 1'b1;
        x_addr  = AW'(REG_TPS);
        x_wdata = DW'({1'b1, 3'b000, (phase == PH_FL) ? 2'd1 : 2'd2});
      end
      OP_POLL: x_addr = stat_addr;
      OP_LO:   x_addr = cnt_addr;
      OP_HI:   x_addr = cnt_addr + AW'(1);
      default: x_addr = '0;
    endcase
  end

  assign cnt_full = {x_rdata, cnt_lo};
  assign lock_ok  = (phase == PH_FL) ? x_rdata[cr_bit]
                                     : (x_rdata[eq_bit] && x_rdata[sl_bit]);
  assign inj_ok   = (cnt_full == CW'(inj_q)) || (cnt_full == CW'(inj_q) + CW'(1));

  always_comb begin
    t_load = ((st == S_PAT) && pat_ack_i && (phase == PH_INJ)) ||
             ((st == S_XWAIT) && x_done && !x_fail &&
              ((op == OP_TPS) || ((op == OP_HI) && (phase == PH_BER) && !clr_done)));
    t_val  = (phase == PH_BER) ? TW'(OBS_CYC) : TW'(LOCK_WAIT);
  end

  assign pat_req_o = (st == S_PAT);
  assign pat_idx_o = phase;
  assign done_o    = (st == S_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= S_IDLE;
      phase       <= PH_FL;
      op          <= OP_TPS;
      lane_q      <= '0;
      inj_q       <= '0;
      lim_q       <= '0;
      tries       <= '0;
      clr_done    <= 1'b0;
      cnt_lo      <= '0;
      pass_o      <= 1'b0;
      fail_code_o <= FC_NONE;
    end else begin
      unique case (st)
        S_IDLE: if (start_i) begin
          lane_q      <= lane_i;
          inj_q       <= inj_cnt_i;
          lim_q       <= err_limit_i;
          phase       <= PH_FL;
          tries       <= '0;
          clr_done    <= 1'b0;
          pass_o      <= 1'b0;
          fail_code_o <= FC_NONE;
          st          <= S_PAT;
        end
        S_PAT: if (pat_ack_i) begin
          unique case (phase)
            PH_FL, PH_SL:     begin op <= OP_TPS; st <= S_ISSUE; end
            PH_CLEAN, PH_BER: begin op <= OP_LO;  st <= S_ISSUE; end
            default:          st <= S_WAIT;
          endcase
        end
        S_ISSUE: st <= S_XWAIT;
        S_XWAIT: begin
          if (x_fail) begin
            fail_code_o <= FC_DEFER;
            st          <= S_END;
          end else if (x_done) begin
            unique case (op)
              OP_TPS: st <= S_WAIT;
              OP_POLL: begin
                if (lock_ok) begin
                  tries <= '0;
                  phase <= (phase == PH_FL) ? PH_SL : PH_CLEAN;
                  st    <= S_PAT;
                end else if (tries == RW'(MAX_RETRY)) begin
                  fail_code_o <= (phase == PH_FL) ? FC_FL : FC_SL;
                  st          <= S_END;
                end else begin
                  tries <= tries + 1'b1;
                  op    <= OP_TPS;
                  st    <= S_ISSUE;
                end
              end
              OP_LO: begin
                cnt_lo <= x_rdata;
                op     <= OP_HI;
                st     <= S_ISSUE;
              end
              default: begin
                unique case (phase)
                  PH_CLEAN: begin
                    if (cnt_full == '0) begin phase <= PH_INJ; st <= S_PAT; end
                    else begin fail_code_o <= FC_CLEAN; st <= S_END; end
                  end
                  PH_INJ: begin
                    if (inj_ok) begin phase <= PH_BER; st <= S_PAT; end
                    else begin fail_code_o <= FC_INJ; st <= S_END; end
                  end
                  default: begin
                    if (!clr_done) begin
                      clr_done <= 1'b1;   // first read only clears
                      st       <= S_WAIT;
                    end else begin
                      if (cnt_full < lim_q) pass_o <= 1'b1;
                      else fail_code_o <= FC_BER;
                      st <= S_END;
                    end
                  end
                endcase
              end
            endcase
          end
        end
        S_WAIT: if (t_zero) begin
          op <= (phase == PH_FL || phase == PH_SL) ? OP_POLL : OP_LO;
          st <= S_ISSUE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_pass_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o == (fail_code_o == FC_NONE)));

  p_retry_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries <= RW'(MAX_RETRY));

  p_pat_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_req_o && !pat_ack_i) |=> (pat_req_o && $stable(pat_idx_o)));

  p_tps_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o) |-> (addr_o == AW'(REG_TPS) && wdata_o[5] && wdata_o[1:0] != 2'd0));

  p_poll_after_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_ISSUE && op == OP_POLL) |-> $past(t_zero));
endmodule

// File: tb/sim_lt_test_seq.sv
module sim_lt_test_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int LOCK_WAIT = 20;
  localparam int OBS_CYC = 60;
  localparam int MAX_RETRY = 5;
  localparam int MAX_DEFER = 8;
  localparam int RUN_LIMIT = 20000;

  typedef struct packed {
    logic [1:0]  lane;
    logic [7:0]  n;
    logic [15:0] lim;
    logic [2:0]  flf;
    logic [2:0]  slf;
    logic [15:0] clean;
    logic [15:0] inj;
    logic [15:0] ber;
    logic [3:0]  def;
    logic [2:0]  code;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd10, 16'd100, 3'd0, 3'd0, 16'd0, 16'd10, 16'd5,  4'd0, 3'd0},
    '{2'd1, 8'd10, 16'd100, 3'd2, 3'd1, 16'd0, 16'd11, 16'd99, 4'd1, 3'd0},
    '{2'd2, 8'd3,  16'd4,   3'd5, 3'd0, 16'd0, 16'd3,  16'd4,  4'd0, 3'd5},
    '{2'd3, 8'd3,  16'd4,   3'd6, 3'd0, 16'd0, 16'd3,  16'd0,  4'd0, 3'd1},
    '{2'd3, 8'd3,  16'd4,   3'd0, 3'd6, 16'd0, 16'd3,  16'd0,  4'd0, 3'd2},
    '{2'd0, 8'd3,  16'd4,   3'd0, 3'd0, 16'd1, 16'd3,  16'd0,  4'd0, 3'd3},
    '{2'd1, 8'd5,  16'd9,   3'd0, 3'd0, 16'd0, 16'd7,  16'd0,  4'd0, 3'd4},
    '{2'd2, 8'd5,  16'd9,   3'd0, 3'd0, 16'd0, 16'd4,  16'd0,  4'd0, 3'd4},
    '{2'd0, 8'd5,  16'd9,   3'd1, 3'd1, 16'd0, 16'd5,  16'd8,  4'd8, 3'd0},
    '{2'd0, 8'd5,  16'd9,   3'd0, 3'd0, 16'd0, 16'd5,  16'd0,  4'd9, 3'd6},
    '{2'd3, 8'd5,  16'd9,   3'd0, 3'd5, 16'd0, 16'd6,  16'd0,  4'd0, 3'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] lane = '0;
  logic [DW-1:0] inj_cnt = '0;
  logic [2*DW-1:0] err_lim = '0;
  logic pat_req, pat_ack;
  logic [2:0] pat_idx;
  logic req, we, ack, defer;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic done, pass;
  logic [2:0] fcode;

  always #(CLK_PERIOD/2) clk = ~clk;

  lt_test_seq #(
    .AW(AW), .DW(DW), .LOCK_WAIT(LOCK_WAIT), .OBS_CYC(OBS_CYC),
    .MAX_RETRY(MAX_RETRY), .MAX_DEFER(MAX_DEFER)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lane_i(lane),
    .inj_cnt_i(inj_cnt), .err_limit_i(err_lim),
    .pat_req_o(pat_req), .pat_idx_o(pat_idx), .pat_ack_i(pat_ack),
    .req_o(req), .we_o(we), .addr_o(addr), .wdata_o(wdata),
    .ack_i(ack), .defer_i(defer), .rdata_i(rdata),
    .done_o(done), .pass_o(pass), .fail_code_o(fcode)
  );

  int checks = 0;
  int errors = 0;

  // sink configuration, set by the stimulus
  vec_t cv = '0;

  // sink model state
  int cyc = 0;
  int pat_cnt, pat_bad, fl_wr, sl_wr, bad, wait_bad, obs_bad;
  int dcur, fl_polls, sl_polls, ber_hi_reads;
  int last_ref_cyc, clr_cyc;
  bit req_seen;
  logic [1:0] tp;
  logic [15:0] ctr;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_byte(input logic [AW-1:0] a);
    logic [7:0] b;
    logic [3:0] nib;
    b = 8'h77;
    if (tp == 2'd1) nib = (fl_polls >= int'(cv.flf)) ? 4'b0001 : 4'b0110;
    else if (sl_polls >= int'(cv.slf)) nib = 4'b0111;
    else nib = sl_polls[0] ? 4'b0101 : 4'b0011;
    if (a == AW'('h202 + cv.lane[1])) begin
      if (cv.lane[0]) b[7:4] = nib; else b[3:0] = nib;
    end
    return b;
  endfunction

  always @(negedge clk) begin
    cyc++;
    ack   = 1'b0;
    defer = 1'b0;
    rdata = '0;
    if (start) begin
      pat_cnt = 0; pat_bad = 0; fl_wr = 0; sl_wr = 0; bad = 0;
      wait_bad = 0; obs_bad = 0; dcur = 0; fl_polls = 0; sl_polls = 0;
      ber_hi_reads = 0; last_ref_cyc = cyc; clr_cyc = cyc; req_seen = 0;
      tp = 2'd0; ctr = '0;
    end
    if (pat_req && !pat_ack) begin
      pat_ack = 1'b1;
      if (int'(pat_idx) != pat_cnt) pat_bad++;
      case (pat_idx)
        3'd2: ctr = cv.clean;
        3'd3: begin ctr = cv.inj; last_ref_cyc = cyc; end
        3'd4: ctr = 16'h0F0F;
        default: ;
      endcase
      pat_cnt++;
    end else begin
      pat_ack = 1'b0;
    end
    if (req) begin
      if (!req_seen) begin
        req_seen = 1;
        if (!we && (addr == AW'('h202 + cv.lane[1]) ||
                    (pat_cnt == 4 && addr == AW'('h210 + 2*cv.lane))))
          if (cyc - last_ref_cyc <= LOCK_WAIT) wait_bad++;
        if (pat_cnt == 5 && ber_hi_reads == 1 && !we)
          if (cyc - clr_cyc <= OBS_CYC) obs_bad++;
      end
      if (dcur < int'(cv.def)) begin
        defer = 1'b1;
        dcur++;
      end else begin
        ack = 1'b1;
        dcur = 0;
        req_seen = 0;
        if (we) begin
          if (addr != AW'('h102) || (wdata != 8'h21 && wdata != 8'h22)) bad++;
          tp = wdata[1:0];
          if (tp == 2'd1) fl_wr++; else sl_wr++;
          last_ref_cyc = cyc;
        end else if (addr == AW'('h202) || addr == AW'('h203)) begin
          if (addr != AW'('h202 + cv.lane[1])) bad++;
          rdata = stat_byte(addr);
          if (tp == 2'd1) fl_polls++; else sl_polls++;
        end else if (addr == AW'('h210 + 2*cv.lane)) begin
          rdata = ctr[7:0];
        end else if (addr == AW'('h211 + 2*cv.lane)) begin
          rdata = ctr[15:8];
          ctr = '0;
          if (pat_cnt == 5) begin
            ber_hi_reads++;
            if (ber_hi_reads == 1) begin ctr = cv.ber; clr_cyc = cyc; end
          end
        end else begin
          bad++;
        end
      end
    end
  end

  task automatic run_vec(input vec_t v, input int k);
    int wd;
    int exp_pat, exp_fl, exp_sl;
    bit pexp;
    cv = v;
    @(posedge clk); #1;
    lane = v.lane; inj_cnt = v.n; err_lim = v.lim; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wd = 0;
    @(negedge clk);
    while (!done && wd < RUN_LIMIT) begin
      @(negedge clk);
      wd++;
    end
    if (!done) begin
      chk(1'b0, "R11 watchdog", wd, RUN_LIMIT);
      return;
    end
    case (v.code)
      3'd1, 3'd6: exp_pat = 1;
      3'd2: exp_pat = 2;
      3'd3: exp_pat = 3;
      3'd4: exp_pat = 4;
      default: exp_pat = 5;
    endcase
    exp_fl = (v.code == 3'd6) ? 0 : ((int'(v.flf) > MAX_RETRY) ? MAX_RETRY + 1 : int'(v.flf) + 1);
    exp_sl = (v.code == 3'd6 || v.code == 3'd1) ? 0 :
             ((int'(v.slf) > MAX_RETRY) ? MAX_RETRY + 1 : int'(v.slf) + 1);
    pexp = (v.code == 3'd0);
    $display("vector %0d lane %0d code %0d", k, v.lane, fcode);
    // R6 R8 R9 R10 R7: outcome code
    chk(fcode == v.code, "R6/R8/R9/R10/R7 fail code", fcode, v.code);
    chk(pass == pexp, "R11 pass flag", pass, pexp);
    chk(pat_cnt == exp_pat && pat_bad == 0, "R1 pattern order", pat_cnt, exp_pat);
    chk(fl_wr == exp_fl, "R6 R4 frequency attempts", fl_wr, exp_fl);
    chk(sl_wr == exp_sl, "R6 R5 symbol attempts", sl_wr, exp_sl);
    chk(bad == 0, "R2 R4 R8 addresses and write data", bad, 0);
    chk(wait_bad == 0, "R3 settle wait", wait_bad, 0);
    if (v.code == 3'd0 || v.code == 3'd5) begin
      chk(obs_bad == 0 && ber_hi_reads == 2, "R10 clear then observe", ber_hi_reads, 2);
    end
    @(negedge clk);
    chk(!done, "R11 done width", done, 0);
  endtask

  initial begin
    int wd;
    ack = 1'b0; defer = 1'b0; pat_ack = 1'b0; rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(!pat_req && !req && !done && !pass && fcode == 3'd0, "R11 reset outputs",
        {pat_req, req, done, pass}, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!pat_req && !req && !done, "R11 idle after reset", {pat_req, req, done}, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

    // R11 reset in the middle of a run
    cv = VECS[1];
    @(posedge clk); #1;
    lane = cv.lane; inj_cnt = cv.n; err_lim = cv.lim; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (30) @(posedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk(!pat_req && !req && !done && !pass && fcode == 3'd0, "R11 mid-run reset",
        {pat_req, req, done, pass}, 0);
    wd = 0;
    repeat (5) begin
      @(negedge clk);
      if (req || pat_req || done) wd++;
    end
    chk(wd == 0, "R11 stays idle in reset", wd, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    run_vec(VECS[0], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule